// File: doc/BRIEF.md
# Expansion Adapter Control Register

This block is the host-side control word of a console expansion adapter, together with the read steering for the small cartridge register window it shares with the cartridge. It sits on a 16-bit host bus with byte lane enables and keeps three control bits. The first is an adapter enable. The second is an active-low hold on the adapter's slave processors. The third is a bus-owner select that decides whether the host or the slave side may use the adapter's video resources.

While the adapter is enabled, the cartridge window is masked. Every word reads zero except the two words that carry the adapter's 32-bit identifier. While it is disabled, window reads go to the cartridge's own register hardware. An undecoded location then returns 0x00FF, because the cartridge data lines are pulled high. The identifier words stay visible in both states. The enable bit also drives the cartridge-port enable line directly. The hold and owner bits are brought out for the rest of the adapter.

Top module: `xadp_ctrl`

## Requirements
- R1: Reset is asynchronous and active low. In reset and right after it, the enable, hold and owner bits are all 0, so `cart_en`=0, `slave_rst_n`=0 and `owner_slave`=0, and a control read returns 0x0000.
- R2: A control write with both lanes enabled (`bus_be`=2'b11) loads bit 0 (enable), bit 1 (slave run, active-low hold) and bit 15 (owner). A control read returns those bits in the same positions, and every other bit reads 0. A control write with `bus_be`=2'b00 changes nothing.
- R3: A control write with only the low lane enabled (`bus_be`=2'b01) updates bits 0 and 1 only. The owner bit keeps its value.
- R4: A control write with only the high lane enabled (`bus_be`=2'b10) updates bit 15 only. The enable and hold bits keep their values.
- R5: Enable, hold and owner are independent. Setting or clearing enable never moves the hold or the owner, so the adapter can be enabled while both slave processors stay held.
- R6: With enable at 1, a window read returns 0x0000 at every word other than the two identifier words, whatever the cartridge drives.
- R7: With enable at 0, a window read at a non-identifier word returns `cart_rdata` when `cart_ack` is 1, and 0x00FF when `cart_ack` is 0.
- R8: A window read at word `ID_WORD` returns `ID_VAL[31:16]`, and at `ID_WORD`+1 returns `ID_VAL[15:0]`, with enable at 0 or 1.
- R9: `cart_en`, `slave_rst_n` and `owner_slave` equal bits 0, 1 and 15 of the control word from the clock edge after the write.
- R10: `vid_grant` is `vid_req` while the owner bit is 0. While it is 1, the request is refused (`vid_refuse`=1, `vid_grant`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Access targets the control word |
| win_sel | input | 1 | Access targets the cartridge register window |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_be | input | 2 | Byte lanes: bit 1 high byte, bit 0 low byte |
| bus_addr | input | ADDR_W | Word index inside the window |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (0 when no read is selected) |
| cart_ack | input | 1 | Cartridge hardware decodes the addressed word |
| cart_rdata | input | 16 | Data from the cartridge register hardware |
| vid_req | input | 1 | Host request for adapter video resources |
| vid_grant | output | 1 | Host request accepted |
| vid_refuse | output | 1 | Host request refused (slave side owns the bus) |
| cart_en | output | 1 | Cartridge-port enable line, follows enable bit |
| slave_rst_n | output | 1 | Active-low hold for the slave processors |
| owner_slave | output | 1 | 1 = slave side owns the video resources |

## Verification
The bench builds the block with its default parameters: a 7-bit window index (128 words), identifier words at indices 0x76 and 0x77, and identifier value 0x58414450. With these values the window can be probed both at the identifier pair and at ordinary words on either side of it. The walk also reaches every combination of byte lanes against each of the three control bits, including the state where the adapter is enabled while the slave processors stay held.

// File: rtl/xadp_pkg.sv
package xadp_pkg;
  localparam int unsigned EN_POS  = 0;
  localparam int unsigned RUN_POS = 1;
  localparam int unsigned OWN_POS = 15;

  typedef struct packed {
    logic owner;
    logic run_n;   // 1 = slaves released, 0 = held
    logic en;
  } xadp_ctl_t;

  function automatic logic [15:0] ctl_to_word(input xadp_ctl_t c);
    logic [15:0] w;
    w          = '0;
    w[EN_POS]  = c.en;
    w[RUN_POS] = c.run_n;
    w[OWN_POS] = c.owner;
    return w;
  endfunction
endpackage

// File: rtl/xadp_ctl_reg.sv
module xadp_ctl_reg
  import xadp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  logic [1:0] lane,
  input  logic      d_en,
  input  logic      d_run,
  input  logic      d_own,
  output xadp_ctl_t q
);
  xadp_ctl_t q_nxt;
  logic      lo_ce, hi_ce;

  assign lo_ce = wr_en & lane[0];
  assign hi_ce = wr_en & lane[1];

  always_comb begin
    q_nxt = q;
    if (lo_ce) begin
      q_nxt.en    = d_en;
      q_nxt.run_n = d_run;
    end
    if (hi_ce) begin
      q_nxt.owner = d_own;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  // R4
  hi_lane_keeps_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && lane == 2'b10) |=> ($stable(q.en) && $stable(q.run_n)));
  // R3
  lo_lane_keeps_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && lane == 2'b01) |=> $stable(q.owner));
  // R2
  no_lane_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || lane == 2'b00) |=> $stable(q));
endmodule

// File: rtl/xadp_win_mux.sv
module xadp_win_mux #(
  parameter int unsigned ADDR_W  = 7,
  parameter int unsigned ID_WORD = 7'h76,
  parameter logic [31:0] ID_VAL  = 32'h5841_4450,
  parameter logic [15:0] PULL_UP = 16'h00FF
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              en,
  input  logic              cart_ack,
  input  logic [15:0]       cart_rdata,
  output logic [15:0]       win_rdata
);
  localparam int unsigned N_ID = 2;
  localparam logic [ADDR_W-1:0] ID_BASE = ADDR_W'(ID_WORD);

  logic [N_ID-1:0]  id_hit;
  logic [15:0]      id_data [N_ID];

  for (genvar k = 0; k < N_ID; k++) begin : g_id
    assign id_hit[k]  = (addr == ID_BASE + ADDR_W'(k));
    assign id_data[k] = ID_VAL[16*(N_ID-1-k) +: 16];
  end

  always_comb begin
    if (id_hit[0])      win_rdata = id_data[0];
    else if (id_hit[1]) win_rdata = id_data[1];
    else if (en)        win_rdata = 16'h0000;
    else if (cart_ack)  win_rdata = cart_rdata;
    else                win_rdata = PULL_UP;
  end
endmodule

// File: rtl/xadp_vid_gate.sv
module xadp_vid_gate (
  input  logic req,
  input  logic owner_slave,
  output logic grant,
  output logic refuse
);
  assign grant  = req & ~owner_slave;
  assign refuse = req &  owner_slave;
endmodule

// File: rtl/xadp_ctrl.sv
module xadp_ctrl
  import xadp_pkg::*;
#(
  parameter int unsigned ADDR_W  = 7,
  parameter int unsigned ID_WORD = 7'h76,
  parameter logic [31:0] ID_VAL  = 32'h5841_4450
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              win_sel,
  input  logic              bus_wr,
  input  logic [1:0]        bus_be,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  input  logic              cart_ack,
  input  logic [15:0]       cart_rdata,
  input  logic              vid_req,
  output logic              vid_grant,
  output logic              vid_refuse,
  output logic              cart_en,
  output logic              slave_rst_n,
  output logic              owner_slave
);
  xadp_ctl_t   ctl;
  logic [15:0] win_data;
  logic        wd_unused;

  assign wd_unused = ^bus_wdata[14:2];

  xadp_ctl_reg u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (reg_sel & bus_wr),
    .lane  (bus_be),
    .d_en  (bus_wdata[EN_POS]),
    .d_run (bus_wdata[RUN_POS]),
    .d_own (bus_wdata[OWN_POS]),
    .q     (ctl)
  );

  xadp_win_mux #(
    .ADDR_W  (ADDR_W),
    .ID_WORD (ID_WORD),
    .ID_VAL  (ID_VAL)
  ) u_win (
    .addr       (bus_addr),
    .en         (ctl.en),
    .cart_ack   (cart_ack),
    .cart_rdata (cart_rdata),
    .win_rdata  (win_data)
  );

  xadp_vid_gate u_vid (
    .req         (vid_req),
    .owner_slave (ctl.owner),
    .grant       (vid_grant),
    .refuse      (vid_refuse)
  );

  always_comb begin
    if (reg_sel && !bus_wr)      bus_rdata = ctl_to_word(ctl);
    else if (win_sel && !bus_wr) bus_rdata = win_data;
    else                         bus_rdata = 16'h0000;
  end

  assign cart_en     = ctl.en;
  assign slave_rst_n = ctl.run_n;
  assign owner_slave = ctl.owner;

  // R10
  refused_when_slave_owns_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_req && owner_slave) |-> (!vid_grant && vid_refuse));
  // R6
  masked_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_sel && !reg_sel && !bus_wr && cart_en &&
     bus_addr != ADDR_W'(ID_WORD) && bus_addr != ADDR_W'(ID_WORD + 1)) |-> (bus_rdata == 16'h0000));
  // R8
  id_hi_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_sel && !reg_sel && !bus_wr && bus_addr == ADDR_W'(ID_WORD)) |-> (bus_rdata == ID_VAL[31:16]));
  // R9
  port_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && bus_wr && bus_be == 2'b11) |=>
      (cart_en == $past(bus_wdata[0]) && slave_rst_n == $past(bus_wdata[1]) &&
       owner_slave == $past(bus_wdata[15])));
endmodule

// File: tb/test_xadp_ctrl.sv
`timescale 1ns/1ps
module test_xadp_ctrl;
  localparam int unsigned AW = 7;

  logic clk, rst_n, reg_sel, win_sel, bus_wr, cart_ack, vid_req;
  logic [1:0]    bus_be;
  logic [AW-1:0] bus_addr;
  logic [15:0]   bus_wdata, bus_rdata, cart_rdata;
  logic vid_grant, vid_refuse, cart_en, slave_rst_n, owner_slave;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  xadp_ctrl i_xadp_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .win_sel(win_sel),
    .bus_wr(bus_wr), .bus_be(bus_be), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cart_ack(cart_ack),
    .cart_rdata(cart_rdata), .vid_req(vid_req), .vid_grant(vid_grant),
    .vid_refuse(vid_refuse), .cart_en(cart_en), .slave_rst_n(slave_rst_n),
    .owner_slave(owner_slave)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  // op: 0 control write, 1 control read, 2 window read; st = {owner, run, en}
  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  be;
    logic [6:0]  addr;
    logic [15:0] wd;
    logic        ack;
    logic [15:0] cd;
    logic [15:0] exp_rd;
    logic [2:0]  st;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 2'b11, 7'h00, 16'h0000, 1'b0, 16'h0000, 16'h0000, 3'b000, 4'd1},  // R1
    '{2'd2, 2'b11, 7'h10, 16'h0000, 1'b1, 16'h1234, 16'h1234, 3'b000, 4'd7},  // R7
    '{2'd2, 2'b11, 7'h11, 16'h0000, 1'b0, 16'h9999, 16'h00FF, 3'b000, 4'd7},  // R7
    '{2'd2, 2'b11, 7'h76, 16'h0000, 1'b1, 16'hAAAA, 16'h5841, 3'b000, 4'd8},  // R8
    '{2'd2, 2'b11, 7'h77, 16'h0000, 1'b1, 16'hAAAA, 16'h4450, 3'b000, 4'd8},  // R8
    '{2'd0, 2'b01, 7'h00, 16'hFFFF, 1'b0, 16'h0000, 16'h0000, 3'b011, 4'd3},  // R3
    '{2'd1, 2'b11, 7'h00, 16'h0000, 1'b0, 16'h0000, 16'h0003, 3'b011, 4'd2},  // R2
    '{2'd0, 2'b10, 7'h00, 16'h8000, 1'b0, 16'h0000, 16'h0000, 3'b111, 4'd4},  // R4
    '{2'd1, 2'b11, 7'h00, 16'h0000, 1'b0, 16'h0000, 16'h8003, 3'b111, 4'd2},  // R2
    '{2'd0, 2'b01, 7'h00, 16'h0000, 1'b0, 16'h0000, 16'h0000, 3'b100, 4'd3},  // R3
    '{2'd0, 2'b11, 7'h00, 16'h7FFC, 1'b0, 16'h0000, 16'h0000, 3'b000, 4'd2},  // R2
    '{2'd0, 2'b11, 7'h00, 16'h8001, 1'b0, 16'h0000, 16'h0000, 3'b101, 4'd5},  // R5
    '{2'd1, 2'b11, 7'h00, 16'h0000, 1'b0, 16'h0000, 16'h8001, 3'b101, 4'd9},  // R9
    '{2'd2, 2'b11, 7'h10, 16'h0000, 1'b1, 16'h1234, 16'h0000, 3'b101, 4'd6},  // R6
    '{2'd2, 2'b11, 7'h11, 16'h0000, 1'b0, 16'h9999, 16'h0000, 3'b101, 4'd6},  // R6
    '{2'd2, 2'b11, 7'h76, 16'h0000, 1'b1, 16'h1234, 16'h5841, 3'b101, 4'd8},  // R8
    '{2'd2, 2'b11, 7'h77, 16'h0000, 1'b1, 16'h1234, 16'h4450, 3'b101, 4'd8},  // R8
    '{2'd0, 2'b10, 7'h00, 16'h0000, 1'b0, 16'h0000, 16'h0000, 3'b001, 4'd4},  // R4
    '{2'd0, 2'b01, 7'h00, 16'h0002, 1'b0, 16'h0000, 16'h0000, 3'b010, 4'd5},  // R5
    '{2'd2, 2'b11, 7'h77, 16'h0000, 1'b1, 16'h5555, 16'h4450, 3'b010, 4'd8},  // R8
    '{2'd0, 2'b00, 7'h00, 16'hFFFF, 1'b0, 16'h0000, 16'h0000, 3'b010, 4'd2}   // R2
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    reg_sel = 1; win_sel = 0; bus_wr = 1; bus_be = be; bus_wdata = d;
    @(negedge clk);
    reg_sel = 0; bus_wr = 0;
  endtask

  initial begin
    rst_n = 0; reg_sel = 0; win_sel = 0; bus_wr = 0; bus_be = 0;
    bus_addr = 0; bus_wdata = 0; cart_ack = 0; cart_rdata = 0; vid_req = 0;
    #1;
    // R1: reset state at the ports
    chk("R1 ports in reset", {29'd0, owner_slave, slave_rst_n, cart_en}, 32'd0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      @(negedge clk);
      reg_sel   = (v.op != 2'd2);
      win_sel   = (v.op == 2'd2);
      bus_wr    = (v.op == 2'd0);
      bus_be    = v.be;
      bus_addr  = v.addr;
      bus_wdata = v.wd;
      cart_ack  = v.ack;
      cart_rdata = v.cd;
      #1;
      if (v.op != 2'd0) chk($sformatf("R%0d read vec %0d", v.req, i), {16'd0, bus_rdata}, {16'd0, v.exp_rd});
      @(posedge clk); #1;
      // R9: outputs follow the stored bits
      chk($sformatf("R%0d/R9 state vec %0d", v.req, i),
          {29'd0, owner_slave, slave_rst_n, cart_en}, {29'd0, v.st});
    end
    @(negedge clk);
    reg_sel = 0; win_sel = 0; bus_wr = 0;

    // R10: owner decides video access
    wr_ctl(2'b11, 16'h8000);
    vid_req = 1; #1;
    chk("R10 refused with slave owner", {30'd0, vid_grant, vid_refuse}, 32'b01);
    wr_ctl(2'b11, 16'h0000);
    #1;
    chk("R10 granted with host owner", {30'd0, vid_grant, vid_refuse}, 32'b10);
    vid_req = 0; #1;
    chk("R10 idle without request", {30'd0, vid_grant, vid_refuse}, 32'b00);

    // R5: enabling with slaves held leaves them held, owner untouched
    wr_ctl(2'b01, 16'h0001);
    #1;
    chk("R5 enable keeps hold", {29'd0, owner_slave, slave_rst_n, cart_en}, 32'b001);

    // R1: asynchronous reset mid-run, without a clock edge
    wr_ctl(2'b11, 16'h8003);
    #1 rst_n = 0; #0.5;
    chk("R1 async clear", {29'd0, owner_slave, slave_rst_n, cart_en}, 32'd0);
    @(negedge clk) rst_n = 1;
    reg_sel = 1; bus_wr = 0; #1;
    chk("R1 read after reset", {16'd0, bus_rdata}, 32'd0);
    reg_sel = 0;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule